// File: doc/BRIEF.md
# Transmit Packet Framer

The framer turns one packet request into an ordered stream of symbol requests for a downstream spreader and modulator. A frame is built from these sections, in this order:

- a programmable number of preamble repetitions;
- an optional pair of start-of-packet framing symbols;
- an optional one-byte length field;
- the payload bytes, taken from an upstream source;
- an optional two-byte CRC, whose value comes from a companion CRC unit.

Every request carries a kind tag. The length, payload and CRC requests also carry the data mode captured at the start of the frame, because the body of a packet goes out at a single rate. The preamble and the framing symbols use their own codes and are outside that mode.

The controller is a single state machine with eight named states. IDLE waits for a start strobe and captures the configuration. PRE emits preamble repetitions. SOP1 and SOP2 emit the two framing symbols. LEN emits the payload byte count. PAY forwards payload bytes. CRC1 and CRC2 emit the two CRC bytes.

The transitions skip every section that is disabled or empty:

- IDLE→PRE happens when the preamble count is non-zero.
- IDLE→SOP1 and PRE→SOP1 are taken when framing is in effect.
- Otherwise the machine enters the first body section, in the order LEN, PAY, CRC1.
- SOP1→SOP2 and CRC1→CRC2 always follow.
- Any state returns to IDLE after its last accepted request, and that return raises the done pulse.

Top module: `pkt_tx_framer`

## Requirements
- R1: After reset, sym_valid_o, pay_ready_o and done_o are all low.
- R2: The start strobe is accepted only in IDLE and captures every configuration input at that moment.
  - A start strobe during a frame is ignored, so no extra frame follows.
  - Configuration changes after acceptance do not affect the frame being sent.
- R3: The preamble is emitted as exactly cfg_pre_cnt_i symbols of kind 0 with data 0. A count of 0 emits none.
- R4: Framing is in effect when any of the following holds, with mode codes 0=GFSK, 1=8DR, 2=DDR, 3=SDR:
  - the mode is 0 or 1;
  - the mode is 2 and cfg_sop_en_i is high.
  - In SDR mode framing is never in effect.
  - When framing is in effect, a kind 1 symbol and then a kind 2 symbol are emitted, both with data 0.
- R5: The length field (kind 3) is emitted when framing is in effect or cfg_len_en_i is high. Its data is the captured cfg_pay_len_i.
- R6: Exactly cfg_pay_len_i payload bytes are forwarded in order as kind 4 requests. pay_ready_o is high only in the payload section while sym_ready_i is high. A length of 0 forwards none.
- R7: When cfg_crc_en_i is high, two kind 5 requests follow the payload, high byte of crc_i first. The value is sampled when the first CRC byte is accepted.
- R8: Every length, payload and CRC request carries on sym_mode_o the mode captured at start.
- R9: done_o is high for exactly the one cycle after the last request of a frame is accepted. For a frame with no sections, that is the cycle after the start strobe. No request is valid in that cycle.
- R10: A preamble, framing or length request that is not accepted stays valid with unchanged kind and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-frame strobe |
| cfg_pre_cnt_i | input | PRE_W | Number of preamble repetitions |
| cfg_mode_i | input | 2 | Data mode: 0 GFSK, 1 8DR, 2 DDR, 3 SDR |
| cfg_sop_en_i | input | 1 | Request framing symbols (honoured in DDR only; forced in GFSK/8DR) |
| cfg_len_en_i | input | 1 | Request the length field when framing is not in effect |
| cfg_crc_en_i | input | 1 | Append the two CRC bytes |
| cfg_pay_len_i | input | 8 | Payload byte count |
| pay_data_i | input | 8 | Payload byte |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_ready_o | output | 1 | Payload byte taken |
| crc_i | input | 16 | CRC value from the CRC unit |
| sym_valid_o | output | 1 | Symbol request valid |
| sym_ready_i | input | 1 | Downstream accepts the request |
| sym_kind_o | output | 3 | 0 preamble, 1 first framing, 2 second framing, 3 length, 4 payload, 5 CRC |
| sym_data_o | output | 8 | Byte carried by the request |
| sym_mode_o | output | 2 | Data mode captured at start |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the framer with its default parameters:

- PRE_W of 4, so the largest preamble count of 15 is reached in a directed frame.
- CRC_MSB_FIRST set, so the high CRC byte must come first.

The 8-bit payload count allows a directed 255-byte frame, which carries the payload counter through its full range. The random frames cover every mode against every combination of framing and length requests, with random back-pressure and payload gaps. Configuration is scrambled during each frame, and a second start strobe is sent mid-frame, to exercise the capture-and-ignore rule.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 2;
    localparam int KIND_W = 3;

    localparam logic [MODE_W-1:0] MODE_GFSK = 2'd0;
    localparam logic [MODE_W-1:0] MODE_8DR  = 2'd1;
    localparam logic [MODE_W-1:0] MODE_DDR  = 2'd2;
    localparam logic [MODE_W-1:0] MODE_SDR  = 2'd3;

    typedef enum logic [KIND_W-1:0] {
        K_PRE  = 3'd0,
        K_SOP1 = 3'd1,
        K_SOP2 = 3'd2,
        K_LEN  = 3'd3,
        K_DATA = 3'd4,
        K_CRC  = 3'd5
    } kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_SOP1, S_SOP2, S_LEN, S_PAY, S_CRC1, S_CRC2
    } state_t;
endpackage

// File: rtl/txf_downcnt.sv
module txf_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == W'(1));
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/txf_crc_order.sv
module txf_crc_order #(
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic [2*txf_pkg::BYTE_W-1:0] crc,
    output logic [txf_pkg::BYTE_W-1:0]   first_b,
    output logic [txf_pkg::BYTE_W-1:0]   second_b
);
    localparam int BW = txf_pkg::BYTE_W;

    generate
        if (MSB_FIRST) begin : g_msb
            assign first_b  = crc[2*BW-1:BW];
            assign second_b = crc[BW-1:0];
        end else begin : g_lsb
            assign first_b  = crc[BW-1:0];
            assign second_b = crc[2*BW-1:BW];
        end
    endgenerate
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
    import txf_pkg::*;
#(
    parameter int PRE_W         = 4,
    parameter bit CRC_MSB_FIRST = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [PRE_W-1:0]    cfg_pre_cnt_i,
    input  logic [MODE_W-1:0]   cfg_mode_i,
    input  logic                cfg_sop_en_i,
    input  logic                cfg_len_en_i,
    input  logic                cfg_crc_en_i,
    input  logic [BYTE_W-1:0]   cfg_pay_len_i,
    input  logic [BYTE_W-1:0]   pay_data_i,
    input  logic                pay_valid_i,
    output logic                pay_ready_o,
    input  logic [2*BYTE_W-1:0] crc_i,
    output logic                sym_valid_o,
    input  logic                sym_ready_i,
    output logic [KIND_W-1:0]   sym_kind_o,
    output logic [BYTE_W-1:0]   sym_data_o,
    output logic [MODE_W-1:0]   sym_mode_o,
    output logic                done_o
);
    state_t state_q, state_n;

    logic [MODE_W-1:0] mode_q;
    logic              sop_q, len_q, crc_q;
    logic [BYTE_W-1:0] plen_q;
    logic [BYTE_W-1:0] crc2_q;
    logic              done_q;

    logic sop_in, len_in, accept, fire, finish;
    logic pre_last, pre_zero, pay_last, pay_zero;
    logic [BYTE_W-1:0] crc_first, crc_second;

    // Framing is forced in GFSK/8DR, optional in DDR, unavailable in SDR.
    assign sop_in = (cfg_mode_i == MODE_GFSK) || (cfg_mode_i == MODE_8DR) ||
                    ((cfg_mode_i == MODE_DDR) && cfg_sop_en_i);
    assign len_in = sop_in || cfg_len_en_i;
    assign accept = (state_q == S_IDLE) && start_i;
    assign fire   = sym_valid_o && sym_ready_i;
    assign finish = (state_n == S_IDLE) && ((state_q != S_IDLE) || start_i);

    function automatic state_t body_entry(input logic with_len,
                                          input logic has_pay,
                                          input logic with_crc);
        if (with_len)      return S_LEN;
        else if (has_pay)  return S_PAY;
        else if (with_crc) return S_CRC1;
        else               return S_IDLE;
    endfunction

    txf_downcnt #(.W(PRE_W)) u_pre_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cfg_pre_cnt_i),
        .dec      (fire && (state_q == S_PRE)),
        .last     (pre_last),
        .zero     (pre_zero)
    );

    txf_downcnt #(.W(BYTE_W)) u_pay_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cfg_pay_len_i),
        .dec      (fire && (state_q == S_PAY)),
        .last     (pay_last),
        .zero     (pay_zero)
    );

    txf_crc_order #(.MSB_FIRST(CRC_MSB_FIRST)) u_crc_order (
        .crc      (crc_i),
        .first_b  (crc_first),
        .second_b (crc_second)
    );

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: if (start_i) begin
                if (cfg_pre_cnt_i != '0) state_n = S_PRE;
                else if (sop_in)         state_n = S_SOP1;
                else state_n = body_entry(len_in, cfg_pay_len_i != '0, cfg_crc_en_i);
            end
            S_PRE: if (fire && (pre_last || pre_zero)) begin
                if (sop_q) state_n = S_SOP1;
                else       state_n = body_entry(len_q, !pay_zero, crc_q);
            end
            S_SOP1: if (fire) state_n = S_SOP2;
            S_SOP2: if (fire) state_n = body_entry(len_q, !pay_zero, crc_q);
            S_LEN:  if (fire) state_n = body_entry(1'b0, !pay_zero, crc_q);
            S_PAY:  if (fire && (pay_last || pay_zero))
                        state_n = crc_q ? S_CRC1 : S_IDLE;
            S_CRC1: if (fire) state_n = S_CRC2;
            S_CRC2: if (fire) state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // State and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= '0;
            sop_q   <= 1'b0;
            len_q   <= 1'b0;
            crc_q   <= 1'b0;
            plen_q  <= '0;
            crc2_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            done_q  <= finish;
            if (accept) begin
                mode_q <= cfg_mode_i;
                sop_q  <= sop_in;
                len_q  <= len_in;
                crc_q  <= cfg_crc_en_i;
                plen_q <= cfg_pay_len_i;
            end
            if (fire && (state_q == S_CRC1))
                crc2_q <= crc_second;
        end
    end

    // Outputs
    always_comb begin
        sym_valid_o = 1'b1;
        sym_kind_o  = K_PRE;
        sym_data_o  = '0;
        pay_ready_o = 1'b0;
        unique case (state_q)
            S_IDLE: sym_valid_o = 1'b0;
            S_PRE:  sym_kind_o  = K_PRE;
            S_SOP1: sym_kind_o  = K_SOP1;
            S_SOP2: sym_kind_o  = K_SOP2;
            S_LEN: begin
                sym_kind_o = K_LEN;
                sym_data_o = plen_q;
            end
            S_PAY: begin
                sym_kind_o  = K_DATA;
                sym_valid_o = pay_valid_i;
                sym_data_o  = pay_data_i;
                pay_ready_o = sym_ready_i;
            end
            S_CRC1: begin
                sym_kind_o = K_CRC;
                sym_data_o = crc_first;
            end
            S_CRC2: begin
                sym_kind_o = K_CRC;
                sym_data_o = crc2_q;
            end
            default: sym_valid_o = 1'b0;
        endcase
    end

    assign sym_mode_o = mode_q;
    assign done_o     = done_q;
endmodule

// File: rtl/txf_checker.sv
module txf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid_o,
    input logic       sym_ready_i,
    input logic [2:0] sym_kind_o,
    input logic [7:0] sym_data_o,
    input logic [1:0] sym_mode_o,
    input logic       pay_ready_o,
    input logic       done_o
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o && !sym_ready_i && (sym_kind_o <= 3'd3)
        |=> sym_valid_o && $stable(sym_kind_o) && $stable(sym_data_o)); // R10

    AST_PULL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready_o |-> sym_ready_i && (sym_kind_o == 3'd4)); // R6

    AST_SOP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o && sym_ready_i && (sym_kind_o == 3'd1)
        |=> sym_valid_o && (sym_kind_o == 3'd2)); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sym_valid_o && !pay_ready_o); // R9

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o && (sym_kind_o >= 3'd3) && $past(sym_valid_o && (sym_kind_o >= 3'd3))
        |-> $stable(sym_mode_o)); // R8
endmodule

bind pkt_tx_framer txf_checker u_txf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid_o (sym_valid_o),
    .sym_ready_i (sym_ready_i),
    .sym_kind_o  (sym_kind_o),
    .sym_data_o  (sym_data_o),
    .sym_mode_o  (sym_mode_o),
    .pay_ready_o (pay_ready_o),
    .done_o      (done_o)
);

// File: tb/tb_pkt_tx_framer.sv
`timescale 1ns/1ps
module tb_pkt_tx_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  cfg_pre_cnt_i = '0;
    logic [1:0]  cfg_mode_i = '0;
    logic        cfg_sop_en_i = 1'b0, cfg_len_en_i = 1'b0, cfg_crc_en_i = 1'b0;
    logic [7:0]  cfg_pay_len_i = '0;
    logic [7:0]  pay_data_i = '0;
    logic        pay_valid_i = 1'b0;
    logic        pay_ready_o;
    logic [15:0] crc_i = '0;
    logic        sym_valid_o;
    logic        sym_ready_i = 1'b0;
    logic [2:0]  sym_kind_o;
    logic [7:0]  sym_data_o;
    logic [1:0]  sym_mode_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    logic [2:0] exp_kind[$];
    logic [7:0] exp_data[$];
    logic [7:0] pay_q[$];

    always #5 clk = ~clk;

    pkt_tx_framer dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic bit sop_eff(input logic [1:0] mode, input logic sop_en);
        return (mode == 2'd0) || (mode == 2'd1) || ((mode == 2'd2) && sop_en);
    endfunction

    task automatic build_expect(input int pre, input logic [1:0] mode, input logic sop_en,
                                input logic len_en, input logic crc_en, input int len,
                                input logic [15:0] crc);
        exp_kind.delete(); exp_data.delete();
        for (int i = 0; i < pre; i++) begin exp_kind.push_back(3'd0); exp_data.push_back(8'd0); end
        if (sop_eff(mode, sop_en)) begin
            exp_kind.push_back(3'd1); exp_data.push_back(8'd0);
            exp_kind.push_back(3'd2); exp_data.push_back(8'd0);
        end
        if (sop_eff(mode, sop_en) || len_en) begin
            exp_kind.push_back(3'd3); exp_data.push_back(8'(len));
        end
        for (int i = 0; i < len; i++) begin exp_kind.push_back(3'd4); exp_data.push_back(pay_q[i]); end
        if (crc_en) begin
            exp_kind.push_back(3'd5); exp_data.push_back(crc[15:8]);
            exp_kind.push_back(3'd5); exp_data.push_back(crc[7:0]);
        end
    endtask

    task automatic run_frame(input int pre, input logic [1:0] mode, input logic sop_en,
                             input logic len_en, input logic crc_en, input int len,
                             input bit mid_start, input int stall_pct);
        int cyc = 0, got = 0, last_acc = 0, pidx = 0;
        bit fin = 0, hold_pend = 0;
        logic [2:0] hk; logic [7:0] hd;
        logic [15:0] crc = 16'($urandom);
        pay_q.delete();
        for (int i = 0; i < len; i++) pay_q.push_back(8'($urandom));
        build_expect(pre, mode, sop_en, len_en, crc_en, len, crc);
        if (exp_kind.size() < 4) mid_start = 0;
        @(negedge clk);
        start_i = 1'b1; cfg_pre_cnt_i = 4'(pre); cfg_mode_i = mode; cfg_sop_en_i = sop_en;
        cfg_len_en_i = len_en; cfg_crc_en_i = crc_en; cfg_pay_len_i = 8'(len); crc_i = crc;
        while (!fin && cyc < 3000) begin
            if (cyc > 0) begin
                @(negedge clk);
                start_i = mid_start && (cyc == 3);
                cfg_pre_cnt_i = 4'($urandom); cfg_mode_i = 2'($urandom);
                cfg_sop_en_i = 1'($urandom); cfg_len_en_i = 1'($urandom);
                cfg_crc_en_i = 1'($urandom); cfg_pay_len_i = 8'($urandom);
            end
            sym_ready_i = ($urandom % 100) >= stall_pct;
            pay_valid_i = (pidx < len) && (($urandom % 100) >= stall_pct);
            pay_data_i  = (pidx < len) ? pay_q[pidx] : 8'($urandom);
            #1;
            if (hold_pend && !(sym_valid_o && sym_kind_o == hk && sym_data_o == hd))
                check(0, "R10 held request", {sym_kind_o, sym_data_o}, {hk, hd});
            hold_pend = 0;
            if (pay_ready_o && !sym_ready_i) check(0, "R6 pull without ready", 1, 0);
            if (done_o) begin
                check(cyc == last_acc + 1, "R9 done timing", cyc, last_acc + 1);
                fin = 1;
            end
            if (sym_valid_o && sym_ready_i) begin
                if (got < exp_kind.size()) begin
                    check(sym_kind_o == exp_kind[got], "R3/R4/R5/R6/R7 kind", sym_kind_o, exp_kind[got]);
                    check(sym_data_o == exp_data[got], "R5/R6/R7 data", sym_data_o, exp_data[got]);
                    if (exp_kind[got] >= 3'd3)
                        check(sym_mode_o == mode, "R8 mode tag", sym_mode_o, mode);
                end else check(0, "R2 extra request", got, exp_kind.size());
                got++;
                last_acc = cyc;
            end else if (sym_valid_o && sym_kind_o <= 3'd3) begin
                hold_pend = 1; hk = sym_kind_o; hd = sym_data_o;
            end
            if (pay_valid_i && pay_ready_o) pidx++;
            cyc++;
        end
        check(fin, "R9 done seen", fin, 1);
        check(got == exp_kind.size(), "R2 request count", got, exp_kind.size());
        check(pidx == len, "R6 bytes pulled", pidx, len);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            start_i = 1'b0; sym_ready_i = 1'b1; pay_valid_i = 1'b1;
            #1;
            check(!sym_valid_o && !done_o && !pay_ready_o, "R2 no restart", sym_valid_o, 0);
        end
        pay_valid_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        sym_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!sym_valid_o && !pay_ready_o && !done_o, "R1 reset outputs",
              {sym_valid_o, pay_ready_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!sym_valid_o && !pay_ready_o && !done_o, "R1 idle outputs",
              {sym_valid_o, pay_ready_o, done_o}, 0);

        // Directed corners
        run_frame(0, 2'd3, 1'b0, 1'b0, 1'b0, 0, 0, 0);    // R9 empty frame
        run_frame(0, 2'd3, 1'b1, 1'b0, 1'b1, 3, 0, 0);    // R4 SDR ignores framing request
        run_frame(2, 2'd0, 1'b0, 1'b0, 1'b0, 1, 0, 30);   // R4 GFSK forces framing
        run_frame(1, 2'd2, 1'b1, 1'b0, 1'b1, 0, 1, 40);   // R5 empty payload, R7 CRC
        run_frame(15, 2'd1, 1'b0, 1'b1, 1'b1, 4, 1, 50);  // R3 max preamble
        run_frame(0, 2'd2, 1'b0, 1'b1, 1'b0, 2, 0, 20);   // R5 length without framing
        run_frame(3, 2'd3, 1'b0, 1'b0, 1'b1, 255, 1, 25); // R6 full payload count

        for (int n = 0; n < 60; n++)
            run_frame($urandom % 6, 2'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), $urandom % 12, 1'($urandom), $urandom % 60);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule